// File: doc/BRIEF.md
# Ingress VLAN Tag Classifier

This block gives each received frame a classified VLAN: a tag type, a priority (PCP), a drop-eligible bit (DEI), a VLAN ID and a drop decision. It works from the tag headers that an upstream parser has already extracted, and from the settings of the ingress port. The first stage gives customer (0x8100) tags and any other TPID, such as service tags, equal standing. It picks the outer tag, or the inner tag when the port allows this and one is present. It replaces a priority-tag VID of zero with the port default VID.

A policy stage follows the first stage. On a filtering-bridge port that has a port VID (PVID), any frame classified as service-tagged is sent back to the PVID with the port default PCP and DEI, as though it had arrived untagged. On a VLAN-aware port with no PVID, service-tagged frames and priority-tagged frames are marked for drop. The result is registered and is presented one clock after the header strobe.

The port default VID acts as the PVID. VLAN-unaware bridges conventionally get reserved VIDs 4000 to 4095, counting down from 4095 by bridge number, and standalone ports get VID 0. Software loads these values as port defaults, so the block treats them as ordinary VIDs.

Top module: `vtag_classifier`

## Requirements
- R1: out_valid is high exactly one clock after a cycle with hdr_valid high and low otherwise. After reset, out_valid, out_tag_type, out_pcp, out_dei, out_vid and out_drop are all 0.
- R2: A frame with no outer tag, or any frame on a port with cfg_aware low, leaves with out_tag_type 0, the port default PCP, DEI and VID, and out_drop 0. Inner-tag fields have no effect on such a frame.
- R3: On a VLAN-aware port with an outer tag, PCP, DEI and VID come from the outer tag when cfg_inner_ena is low or no inner tag is present.
- R4: When cfg_inner_ena is high and both tags are present, PCP, DEI, VID and the TPID used for the tag type come from the inner tag.
- R5: out_tag_type is 0 when the selected tag's TPID equals 0x8100 and 1 for any other value (for example 0x88A8 or 0x9100).
- R6: When the selected tag's VID is 0, out_vid is the port default VID. The tag's PCP and DEI are kept.
- R7: When cfg_filtering and cfg_pvid_valid are both high and out_tag_type would be 1, out_vid, out_pcp and out_dei are the port defaults, and out_tag_type stays 1.
- R8: When cfg_aware is high and cfg_pvid_valid is low, out_drop is 1 for a frame whose selected tag has tag type 1 or VID 0. out_drop is 0 for a tag of type 0 with a nonzero VID.
- R9: A service-tagged frame keeps its own PCP, DEI and VID when cfg_filtering is low.
- R10: While hdr_valid is low, out_tag_type, out_pcp, out_dei, out_vid and out_drop hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Parsed header fields are valid this cycle |
| outer_present | input | 1 | Frame carries an outer tag |
| outer_tpid | input | 16 | Outer tag TPID |
| outer_pcp | input | 3 | Outer tag priority |
| outer_dei | input | 1 | Outer tag drop-eligible bit |
| outer_vid | input | 12 | Outer tag VLAN ID |
| inner_present | input | 1 | Frame carries an inner tag |
| inner_tpid | input | 16 | Inner tag TPID |
| inner_pcp | input | 3 | Inner tag priority |
| inner_dei | input | 1 | Inner tag drop-eligible bit |
| inner_vid | input | 12 | Inner tag VLAN ID |
| cfg_aware | input | 1 | Port classifies on received tags |
| cfg_inner_ena | input | 1 | Port classifies on the inner tag when present |
| cfg_def_pcp | input | 3 | Port default priority |
| cfg_def_dei | input | 1 | Port default drop-eligible bit |
| cfg_def_vid | input | 12 | Port default VID (the PVID) |
| cfg_pvid_valid | input | 1 | Port has a PVID |
| cfg_filtering | input | 1 | Port belongs to a VLAN-filtering bridge |
| out_valid | output | 1 | Classification result valid |
| out_tag_type | output | 1 | 0 for a 0x8100 tag, 1 for any other TPID |
| out_pcp | output | 3 | Classified priority |
| out_dei | output | 1 | Classified drop-eligible bit |
| out_vid | output | 12 | Classified VLAN ID |
| out_drop | output | 1 | Frame is to be dropped |

## Verification
The hardest case to reach is a double-tagged frame where three port settings interact: the inner tag is selected, and it is also a service tag or a priority tag, so it must pass through inner selection, VID substitution and then the override or the drop policy. The stimulus builds frames whose outer and inner tags differ in every field. Each output value can then come from only one source: the outer tag, the inner tag or the port default. The tests step the port through combinations of filtering and PVID settings with the same tag contents, so that each policy decision is visible on its own.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  localparam int VID_W    = 12;
  localparam int PCP_W    = 3;
  localparam int TPID_W   = 16;
  localparam int NUM_TAGS = 2;

  typedef struct packed {
    logic             present;
    logic [TPID_W-1:0] tpid;
    logic [PCP_W-1:0] pcp;
    logic             dei;
    logic [VID_W-1:0] vid;
  } vtag_hdr_t;

  typedef struct packed {
    logic             s_type;
    logic [PCP_W-1:0] pcp;
    logic             dei;
    logic [VID_W-1:0] vid;
  } vclass_t;

  // Nonzero tag type for anything other than the customer TPID
  function automatic logic service_tpid(input logic [TPID_W-1:0] tpid,
                                        input logic [TPID_W-1:0] ctag);
    return tpid != ctag;
  endfunction

  function automatic logic prio_only(input logic [VID_W-1:0] vid);
    return vid == '0;
  endfunction

  function automatic vclass_t port_default(input logic [PCP_W-1:0] pcp,
                                           input logic dei,
                                           input logic [VID_W-1:0] vid);
    vclass_t c;
    c.s_type = 1'b0;
    c.pcp    = pcp;
    c.dei    = dei;
    c.vid    = vid;
    return c;
  endfunction
endpackage

// File: rtl/vtag_select.sv
module vtag_select
  import vtag_pkg::*;
#(
  parameter logic [TPID_W-1:0] CTAG_TPID = 16'h8100
) (
  input  vtag_hdr_t outer_hdr,
  input  vtag_hdr_t inner_hdr,
  input  logic      cfg_aware,
  input  logic      cfg_inner_ena,
  input  vclass_t   dflt,
  output vclass_t   basic,
  output logic      tag_used,
  output logic      inner_used,
  output logic      prio_tag
);
  vtag_hdr_t           cand [NUM_TAGS];
  logic [NUM_TAGS-1:0] cand_svc;
  logic [NUM_TAGS-1:0] cand_prio;

  assign cand[0] = outer_hdr;
  assign cand[1] = inner_hdr;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_cand
    assign cand_svc[g]  = service_tpid(cand[g].tpid, CTAG_TPID);
    assign cand_prio[g] = prio_only(cand[g].vid);
  end

  assign tag_used   = cfg_aware & outer_hdr.present;
  assign inner_used = tag_used & cfg_inner_ena & inner_hdr.present;

  always_comb begin
    basic    = dflt;
    prio_tag = 1'b0;
    if (tag_used) begin
      basic.s_type = cand_svc[inner_used];
      basic.pcp    = cand[inner_used].pcp;
      basic.dei    = cand[inner_used].dei;
      basic.vid    = cand_prio[inner_used] ? dflt.vid : cand[inner_used].vid;
      prio_tag     = cand_prio[inner_used];
    end
  end
endmodule

// File: rtl/vtag_policy.sv
module vtag_policy
  import vtag_pkg::*;
(
  input  vclass_t basic,
  input  logic    tag_used,
  input  logic    prio_tag,
  input  logic    cfg_aware,
  input  logic    cfg_filtering,
  input  logic    cfg_pvid_valid,
  input  vclass_t dflt,
  output vclass_t final_cls,
  output logic    drop,
  output logic    force_untag
);
  assign force_untag = cfg_filtering & cfg_pvid_valid & tag_used & basic.s_type;
  assign drop        = cfg_aware & ~cfg_pvid_valid & tag_used & (basic.s_type | prio_tag);

  always_comb begin
    final_cls = basic;
    if (force_untag) begin
      final_cls.pcp = dflt.pcp;
      final_cls.dei = dflt.dei;
      final_cls.vid = dflt.vid;
    end
  end
endmodule

// File: rtl/vtag_outreg.sv
module vtag_outreg
  import vtag_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  vclass_t in_cls,
  input  logic    in_drop,
  output logic    q_valid,
  output vclass_t q_cls,
  output logic    q_drop
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_cls   <= '0;
      q_drop  <= 1'b0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_cls  <= in_cls;
        q_drop <= in_drop;
      end
    end
  end
endmodule

// File: rtl/vtag_classifier.sv
module vtag_classifier
  import vtag_pkg::*;
#(
  parameter logic [TPID_W-1:0] CTAG_TPID = 16'h8100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic              outer_present,
  input  logic [TPID_W-1:0] outer_tpid,
  input  logic [PCP_W-1:0]  outer_pcp,
  input  logic              outer_dei,
  input  logic [VID_W-1:0]  outer_vid,
  input  logic              inner_present,
  input  logic [TPID_W-1:0] inner_tpid,
  input  logic [PCP_W-1:0]  inner_pcp,
  input  logic              inner_dei,
  input  logic [VID_W-1:0]  inner_vid,
  input  logic              cfg_aware,
  input  logic              cfg_inner_ena,
  input  logic [PCP_W-1:0]  cfg_def_pcp,
  input  logic              cfg_def_dei,
  input  logic [VID_W-1:0]  cfg_def_vid,
  input  logic              cfg_pvid_valid,
  input  logic              cfg_filtering,
  output logic              out_valid,
  output logic              out_tag_type,
  output logic [PCP_W-1:0]  out_pcp,
  output logic              out_dei,
  output logic [VID_W-1:0]  out_vid,
  output logic              out_drop
);
  vtag_hdr_t outer_hdr, inner_hdr;
  vclass_t   dflt, basic, final_cls, q_cls;
  logic      tag_used, inner_used, prio_tag, force_untag, drop_req;

  assign outer_hdr = '{present: outer_present, tpid: outer_tpid, pcp: outer_pcp,
                       dei: outer_dei, vid: outer_vid};
  assign inner_hdr = '{present: inner_present, tpid: inner_tpid, pcp: inner_pcp,
                       dei: inner_dei, vid: inner_vid};
  assign dflt      = port_default(cfg_def_pcp, cfg_def_dei, cfg_def_vid);

  vtag_select #(.CTAG_TPID(CTAG_TPID)) u_select (
    .outer_hdr     (outer_hdr),
    .inner_hdr     (inner_hdr),
    .cfg_aware     (cfg_aware),
    .cfg_inner_ena (cfg_inner_ena),
    .dflt          (dflt),
    .basic         (basic),
    .tag_used      (tag_used),
    .inner_used    (inner_used),
    .prio_tag      (prio_tag)
  );

  vtag_policy u_policy (
    .basic          (basic),
    .tag_used       (tag_used),
    .prio_tag       (prio_tag),
    .cfg_aware      (cfg_aware),
    .cfg_filtering  (cfg_filtering),
    .cfg_pvid_valid (cfg_pvid_valid),
    .dflt           (dflt),
    .final_cls      (final_cls),
    .drop           (drop_req),
    .force_untag    (force_untag)
  );

  vtag_outreg u_outreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (hdr_valid),
    .in_cls   (final_cls),
    .in_drop  (drop_req),
    .q_valid  (out_valid),
    .q_cls    (q_cls),
    .q_drop   (out_drop)
  );

  assign out_tag_type = q_cls.s_type;
  assign out_pcp      = q_cls.pcp;
  assign out_dei      = q_cls.dei;
  assign out_vid      = q_cls.vid;
endmodule

// File: rtl/vtag_classifier_chk.sv
module vtag_classifier_chk
  import vtag_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             outer_present,
  input logic             cfg_aware,
  input logic             cfg_pvid_valid,
  input logic [PCP_W-1:0] cfg_def_pcp,
  input logic             cfg_def_dei,
  input logic [VID_W-1:0] cfg_def_vid,
  input logic             prio_tag,
  input logic             tag_used,
  input logic             force_untag,
  input logic             out_valid,
  input logic             out_tag_type,
  input logic [PCP_W-1:0] out_pcp,
  input logic             out_dei,
  input logic [VID_W-1:0] out_vid,
  input logic             out_drop
);
  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> out_valid);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !out_valid);
  // R2
  untagged_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !(cfg_aware && outer_present)) |=>
      (out_vid == $past(cfg_def_vid) && !out_tag_type && !out_drop));
  // R6
  prio_vid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && prio_tag) |=> (out_vid == $past(cfg_def_vid)));
  // R7
  force_untag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && force_untag) |=>
      (out_vid == $past(cfg_def_vid) && out_pcp == $past(cfg_def_pcp) &&
       out_dei == $past(cfg_def_dei) && out_tag_type));
  // R8
  pvid_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && (cfg_pvid_valid || !tag_used)) |=> !out_drop);
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(out_vid) && $stable(out_pcp) && $stable(out_dei) &&
                    $stable(out_tag_type) && $stable(out_drop)));
endmodule

bind vtag_classifier vtag_classifier_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hdr_valid      (hdr_valid),
  .outer_present  (outer_present),
  .cfg_aware      (cfg_aware),
  .cfg_pvid_valid (cfg_pvid_valid),
  .cfg_def_pcp    (cfg_def_pcp),
  .cfg_def_dei    (cfg_def_dei),
  .cfg_def_vid    (cfg_def_vid),
  .prio_tag       (prio_tag),
  .tag_used       (tag_used),
  .force_untag    (force_untag),
  .out_valid      (out_valid),
  .out_tag_type   (out_tag_type),
  .out_pcp        (out_pcp),
  .out_dei        (out_dei),
  .out_vid        (out_vid),
  .out_drop       (out_drop)
);

// File: tb/vtag_classifier_bench.sv
module vtag_classifier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        outer_present = 1'b0, inner_present = 1'b0;
  logic [15:0] outer_tpid = 16'h0, inner_tpid = 16'h0;
  logic [2:0]  outer_pcp = 3'd0, inner_pcp = 3'd0;
  logic        outer_dei = 1'b0, inner_dei = 1'b0;
  logic [11:0] outer_vid = 12'd0, inner_vid = 12'd0;
  logic        cfg_aware = 1'b0, cfg_inner_ena = 1'b0;
  logic [2:0]  cfg_def_pcp = 3'd3;
  logic        cfg_def_dei = 1'b1;
  logic [11:0] cfg_def_vid = 12'd123;
  logic        cfg_pvid_valid = 1'b1, cfg_filtering = 1'b0;
  logic        out_valid, out_tag_type, out_dei, out_drop;
  logic [2:0]  out_pcp;
  logic [11:0] out_vid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vtag_classifier u_vtag_classifier (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
    .outer_present(outer_present), .outer_tpid(outer_tpid), .outer_pcp(outer_pcp),
    .outer_dei(outer_dei), .outer_vid(outer_vid),
    .inner_present(inner_present), .inner_tpid(inner_tpid), .inner_pcp(inner_pcp),
    .inner_dei(inner_dei), .inner_vid(inner_vid),
    .cfg_aware(cfg_aware), .cfg_inner_ena(cfg_inner_ena), .cfg_def_pcp(cfg_def_pcp),
    .cfg_def_dei(cfg_def_dei), .cfg_def_vid(cfg_def_vid),
    .cfg_pvid_valid(cfg_pvid_valid), .cfg_filtering(cfg_filtering),
    .out_valid(out_valid), .out_tag_type(out_tag_type), .out_pcp(out_pcp),
    .out_dei(out_dei), .out_vid(out_vid), .out_drop(out_drop)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected: {valid, type, pcp, dei, vid, drop}
  task automatic chk_out(input string req, input int typ, input int pcp, input int dei,
                         input int vid, input int drp);
    chk(req, "valid", int'(out_valid), 1);
    chk(req, "tag_type", int'(out_tag_type), typ);
    chk(req, "pcp", int'(out_pcp), pcp);
    chk(req, "dei", int'(out_dei), dei);
    chk(req, "vid", int'(out_vid), vid);
    chk(req, "drop", int'(out_drop), drp);
  endtask

  task automatic set_outer(input logic p, input logic [15:0] t, input logic [2:0] pc,
                           input logic d, input logic [11:0] v);
    outer_present = p; outer_tpid = t; outer_pcp = pc; outer_dei = d; outer_vid = v;
  endtask

  task automatic set_inner(input logic p, input logic [15:0] t, input logic [2:0] pc,
                           input logic d, input logic [11:0] v);
    inner_present = p; inner_tpid = t; inner_pcp = pc; inner_dei = d; inner_vid = v;
  endtask

  // Present one header for one cycle; result is registered at the edge in between
  task automatic send();
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "reset valid", int'(out_valid), 0);
    chk("R1", "reset vid", int'(out_vid), 0);
    chk("R1", "reset drop", int'(out_drop), 0);
    chk("R1", "reset pcp", int'(out_pcp), 0);
  endtask

  task automatic t_untagged();
    cfg_aware = 1'b1; cfg_inner_ena = 1'b1; cfg_pvid_valid = 1'b0;
    set_outer(1'b0, 16'h8100, 3'd6, 1'b0, 12'd55);
    set_inner(1'b1, 16'h88A8, 3'd5, 1'b0, 12'd66);
    send();
    chk_out("R2", 0, 3, 1, 123, 0);
    cfg_aware = 1'b0;
    set_outer(1'b1, 16'h88A8, 3'd6, 1'b0, 12'd0);
    send();
    chk_out("R2", 0, 3, 1, 123, 0);
    cfg_pvid_valid = 1'b1;
  endtask

  task automatic t_outer();
    cfg_aware = 1'b1; cfg_inner_ena = 1'b0;
    set_outer(1'b1, 16'h8100, 3'd5, 1'b0, 12'd100);
    set_inner(1'b1, 16'h88A8, 3'd1, 1'b1, 12'd200);
    send();
    chk_out("R3", 0, 5, 0, 100, 0);
    cfg_inner_ena = 1'b1;
    set_inner(1'b0, 16'h88A8, 3'd1, 1'b1, 12'd200);
    send();
    chk_out("R3", 0, 5, 0, 100, 0);
  endtask

  task automatic t_inner();
    cfg_aware = 1'b1; cfg_inner_ena = 1'b1;
    set_outer(1'b1, 16'h88A8, 3'd7, 1'b1, 12'd300);
    set_inner(1'b1, 16'h8100, 3'd2, 1'b0, 12'd200);
    send();
    chk_out("R4", 0, 2, 0, 200, 0);
    // inner service tag sets the type even with a customer outer tag (R5)
    set_outer(1'b1, 16'h8100, 3'd7, 1'b1, 12'd300);
    set_inner(1'b1, 16'h9100, 3'd2, 1'b0, 12'd201);
    send();
    chk_out("R4", 1, 2, 0, 201, 0);
  endtask

  task automatic t_type();
    cfg_aware = 1'b1; cfg_inner_ena = 1'b0; cfg_filtering = 1'b0;
    set_inner(1'b0, 16'h0, 3'd0, 1'b0, 12'd0);
    set_outer(1'b1, 16'h88A8, 3'd4, 1'b0, 12'd77);
    send();
    chk_out("R5", 1, 4, 0, 77, 0);
    set_outer(1'b1, 16'h9100, 3'd6, 1'b1, 12'd78);
    send();
    chk_out("R9", 1, 6, 1, 78, 0);
  endtask

  task automatic t_prio();
    cfg_aware = 1'b1; cfg_inner_ena = 1'b0; cfg_filtering = 1'b0;
    set_outer(1'b1, 16'h8100, 3'd6, 1'b0, 12'd0);
    send();
    chk_out("R6", 0, 6, 0, 123, 0);
  endtask

  task automatic t_force();
    cfg_aware = 1'b1; cfg_inner_ena = 1'b1; cfg_filtering = 1'b1; cfg_pvid_valid = 1'b1;
    set_outer(1'b1, 16'h88A8, 3'd7, 1'b0, 12'd33);
    set_inner(1'b0, 16'h0, 3'd0, 1'b0, 12'd0);
    send();
    chk_out("R7", 1, 3, 1, 123, 0);
    // customer tag on the same port keeps its fields
    set_outer(1'b1, 16'h8100, 3'd7, 1'b0, 12'd34);
    send();
    chk_out("R7", 0, 7, 0, 34, 0);
    cfg_filtering = 1'b0;
  endtask

  task automatic t_drop();
    cfg_aware = 1'b1; cfg_inner_ena = 1'b0; cfg_pvid_valid = 1'b0; cfg_filtering = 1'b1;
    set_outer(1'b1, 16'h88A8, 3'd1, 1'b0, 12'd10);
    send();
    chk("R8", "S-tag drop", int'(out_drop), 1);
    set_outer(1'b1, 16'h88A8, 3'd1, 1'b0, 12'd0);
    send();
    chk("R8", "prio S drop", int'(out_drop), 1);
    set_outer(1'b1, 16'h8100, 3'd1, 1'b0, 12'd0);
    send();
    chk("R8", "prio C drop", int'(out_drop), 1);
    set_outer(1'b1, 16'h8100, 3'd1, 1'b0, 12'd10);
    send();
    chk_out("R8", 0, 1, 0, 10, 0);
    cfg_pvid_valid = 1'b1; cfg_filtering = 1'b0;
  endtask

  task automatic t_hold();
    cfg_aware = 1'b1; cfg_inner_ena = 1'b0;
    set_outer(1'b1, 16'h8100, 3'd2, 1'b1, 12'd900);
    send();
    chk_out("R1", 0, 2, 1, 900, 0);
    set_outer(1'b1, 16'h88A8, 3'd5, 1'b0, 12'd0);
    cfg_pvid_valid = 1'b0;
    @(negedge clk);
    chk("R1", "idle valid", int'(out_valid), 0);
    chk("R10", "held vid", int'(out_vid), 900);
    chk("R10", "held drop", int'(out_drop), 0);
    chk("R10", "held type", int'(out_tag_type), 0);
    cfg_pvid_valid = 1'b1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_untagged();
    t_outer();
    t_inner();
    t_type();
    t_prio();
    t_force();
    t_drop();
    t_hold();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule